// File: doc/BRIEF.md
# Latency-Insensitive Relay Cell

This block is a single pipeline stage for a long wire in a latency-insensitive channel. A data word qualified by a valid bit travels downstream through the cell with one clock of delay. A stop request travels upstream through the cell, also with one clock of delay. Several cells placed in a row make a wire section of any length. Each stage adds one cycle in the forward direction and one cycle in the backward direction.

The cell has two storage slots, a primary one and a spare one. When the downstream side stalls, the stop only reaches the upstream neighbour one cycle later. During that cycle a word may still arrive, and the spare slot holds it so that it is not lost. A three-state occupancy controller (empty, one word held, two words held) drives two things. It gates the outgoing valid combinationally with the incoming stop. It raises the upstream stop only while both slots are occupied. If a word arrives while both slots are full and the downstream side is stalling, the cell sets a sticky error flag so that verification can see the protocol violation.

Top module: `li_relay_cell`

## Requirements
- R1: A synchronous active-high reset empties the cell and clears the error flag, so `valOut`, `stopOut` and `overflow` read 0 after it.
- R2: A word accepted into an empty cell appears on `valOut`/`dataOut` in the next cycle (when `stopIn` is low), never in the cycle it arrives; there is no combinational path from `valIn` to `valOut`.
- R3: While `stopIn` is 1, `valOut` is 0 in that same cycle; while at least one word is held and `stopIn` is 0, `valOut` is 1.
- R4: `stopOut` is 1 exactly while two words are held; it rises only in the cycle after one in which `stopIn` was 1 (no combinational path from `stopIn` to `stopOut`).
- R5: An empty cell ignores `stopIn`: `stopOut` and `valOut` stay 0 whatever its value.
- R6: With one word held and `stopIn` 1, an arriving word goes to the spare slot and `stopOut` stays 0 in that cycle; the cell then holds two words.
- R7: With one word held, `stopIn` 0 and a new word arriving, the held word is sent and the new one is kept, so one word is still held.
- R8: While stalled, the presented word (`dataOut`) does not change until it is sent.
- R9: With two words held, `stopIn` 0 and a word arriving, the oldest word is sent, the spare moves forward and the new word is stored, so two words are still held.
- R10: A word arriving with two words held and `stopIn` 1 sets `overflow`, which stays 1 until reset; the two stored words are still delivered intact and in order.
- R11: Through a chain of cells with a source that sends only while `stopOut` is 0, every word leaves in entry order, none is lost or duplicated, and `overflow` never sets.
- R12: `dataOut` carries no meaning while `valOut` is 0; the data width is the parameter `DATA_W` (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valIn | input | 1 | Upstream word valid |
| dataIn | input | DATA_W | Upstream word |
| stopOut | output | 1 | Stop request to upstream, registered |
| valOut | output | 1 | Downstream word valid |
| dataOut | output | DATA_W | Downstream word |
| stopIn | input | 1 | Stop request from downstream |
| overflow | output | 1 | Sticky protocol-violation flag |

## Verification
A standalone cell is built with the default 8-bit width and driven through directed scenarios. These walk every occupancy transition, including the pass-through while full, the stall that fills the spare slot, and the illegal write that sets the overflow flag. A second set of three cells is chained with `DATA_W` set to 16. This width leaves room for sequence numbers that do not wrap over a long random run. Random stalls then exercise back-pressure rippling through several stages, and the scoreboard can prove order and completeness end to end.

// File: rtl/li_relay_pkg.sv
package li_relay_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_HALF  = 2'd1,
    OCC_FULL  = 2'd2
  } occ_e;

  typedef struct packed {
    logic mainLoad;
    logic mainFromAux;
    logic auxLoad;
  } slotCtl_t;

endpackage

// File: rtl/li_relay_ctrl.sv
module li_relay_ctrl
  import li_relay_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     valIn,
  input  logic     stopIn,
  output occ_e     occQ,
  output slotCtl_t slotCtl,
  output logic     valOut,
  output logic     stopOut,
  output logic     overflow
);

  occ_e occD;
  logic overflowQ;
  logic illegalWrite;

  // Mealy outputs: forward valid is gated by the downstream stop of this
  // same section; the upstream stop depends on registered state only.
  assign valOut       = (occQ != OCC_EMPTY) && !stopIn;
  assign stopOut      = (occQ == OCC_FULL);
  assign illegalWrite = (occQ == OCC_FULL) && stopIn && valIn;
  assign overflow     = overflowQ;

  always_comb begin
    occD    = occQ;
    slotCtl = '0;
    unique case (occQ)
      OCC_EMPTY: begin
        if (valIn) begin
          slotCtl.mainLoad = 1'b1;
          occD             = OCC_HALF;
        end
      end
      OCC_HALF: begin
        if (!stopIn) begin
          if (valIn) slotCtl.mainLoad = 1'b1;
          else       occD             = OCC_EMPTY;
        end else if (valIn) begin
          slotCtl.auxLoad = 1'b1;
          occD            = OCC_FULL;
        end
      end
      OCC_FULL: begin
        if (!stopIn) begin
          slotCtl.mainLoad    = 1'b1;
          slotCtl.mainFromAux = 1'b1;
          if (valIn) slotCtl.auxLoad = 1'b1;
          else       occD            = OCC_HALF;
        end
      end
      default: occD = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occQ      <= OCC_EMPTY;
      overflowQ <= 1'b0;
    end else begin
      occQ      <= occD;
      overflowQ <= overflowQ | illegalWrite;
    end
  end

endmodule

// File: rtl/li_relay_dpath.sv
module li_relay_dpath
  import li_relay_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slotCtl_t          slotCtl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] mainQ;
  logic [DATA_W-1:0] auxQ;
  logic [DATA_W-1:0] mainNext;

  assign mainNext = slotCtl.mainFromAux ? auxQ : dataIn;
  assign dataOut  = mainQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      mainQ <= '0;
      auxQ  <= '0;
    end else begin
      if (slotCtl.mainLoad) mainQ <= mainNext;
      if (slotCtl.auxLoad)  auxQ  <= dataIn;
    end
  end

endmodule

// File: rtl/li_relay_cell.sv
module li_relay_cell
  import li_relay_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              stopOut,
  output logic              valOut,
  output logic [DATA_W-1:0] dataOut,
  input  logic              stopIn,
  output logic              overflow
);

  occ_e     occQ;
  slotCtl_t slotCtl;

  li_relay_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .valIn    (valIn),
    .stopIn   (stopIn),
    .occQ     (occQ),
    .slotCtl  (slotCtl),
    .valOut   (valOut),
    .stopOut  (stopOut),
    .overflow (overflow)
  );

  li_relay_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .slotCtl (slotCtl),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/li_relay_chk.sv
module li_relay_chk
  import li_relay_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              valIn,
  input logic [DATA_W-1:0] dataIn,
  input logic              stopOut,
  input logic              valOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              stopIn,
  input logic              overflow,
  input occ_e              occQ
);

  // R2: a word written into an empty cell is presented one cycle later
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (occQ == OCC_EMPTY && valIn) |=> (stopIn || (valOut && dataOut == $past(dataIn))));

  // R3: downstream stop suppresses forward valid in the same cycle
  p_stall_gate_r3: assert property (@(posedge clk) disable iff (rst)
    stopIn |-> !valOut);

  // R4: upstream stop only appears after a stalled cycle
  p_stop_lag_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stopOut) |-> $past(stopIn));

  // R5: an empty cell never stops its upstream neighbour
  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (occQ == OCC_EMPTY) |-> (!stopOut && !valOut));

  // R8: a stalled word stays put until it is sent
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stopIn && occQ != OCC_EMPTY) |=> (stopIn || (valOut && dataOut == $past(dataOut))));

  // R10: overflow is sticky
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10: overflow only follows a write into a full, stalled cell
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(valIn && stopIn && stopOut));

endmodule

bind li_relay_cell li_relay_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valIn    (valIn),
  .dataIn   (dataIn),
  .stopOut  (stopOut),
  .valOut   (valOut),
  .dataOut  (dataOut),
  .stopIn   (stopIn),
  .overflow (overflow),
  .occQ     (occQ)
);

// File: tb/li_relay_cell_tb.sv
`timescale 1ns/1ps
module li_relay_cell_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // standalone cell, default width
  logic       valIn = 0, stopIn = 0;
  logic [7:0] dataIn = '0;
  logic       valOut, stopOut, overflow;
  logic [7:0] dataOut;

  li_relay_cell u_dut (
    .clk(clk), .rst(rst), .valIn(valIn), .dataIn(dataIn), .stopOut(stopOut),
    .valOut(valOut), .dataOut(dataOut), .stopIn(stopIn), .overflow(overflow)
  );

  // three-cell chain, 16-bit sequence numbers
  logic        srcVal = 0, snkStop = 0, chainOn = 0;
  logic [15:0] srcData = '0;
  logic        s0Stop, v01, s10, v12, s21, v2;
  logic [15:0] d01, d12, d2;
  logic        ov0, ov1, ov2;

  li_relay_cell #(.DATA_W(16)) u_c0 (.clk(clk), .rst(rst), .valIn(srcVal), .dataIn(srcData),
    .stopOut(s0Stop), .valOut(v01), .dataOut(d01), .stopIn(s10), .overflow(ov0));
  li_relay_cell #(.DATA_W(16)) u_c1 (.clk(clk), .rst(rst), .valIn(v01), .dataIn(d01),
    .stopOut(s10), .valOut(v12), .dataOut(d12), .stopIn(s21), .overflow(ov1));
  li_relay_cell #(.DATA_W(16)) u_c2 (.clk(clk), .rst(rst), .valIn(v12), .dataIn(d12),
    .stopOut(s21), .valOut(v2), .dataOut(d2), .stopIn(snkStop), .overflow(ov2));

  logic [15:0] expQ[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // drive the standalone cell at the falling edge, settle, then check
  task automatic step(input logic v, input logic [7:0] d, input logic s);
    @(negedge clk);
    valIn = v; dataIn = d; stopIn = s;
    #1;
  endtask

  task automatic expectOut(input string req, input logic [7:0] d);
    chk(valOut == 1'b1, req, valOut, 1);
    chk(dataOut == d, req, dataOut, d);
  endtask

  // scoreboard monitor for the chain
  always begin
    @(negedge clk);
    #2;
    if (!rst && chainOn && v2) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected word", d2, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(d2 == e, "R11 order", d2, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R11 watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] seq;
    seq = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk(valOut == 0, "R1 valOut", valOut, 0);
    chk(stopOut == 0, "R1 stopOut", stopOut, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);

    // R5: empty cell ignores stopIn
    step(0, 8'h00, 1);
    chk(stopOut == 0, "R5 stopOut", stopOut, 0);
    chk(valOut == 0, "R5 valOut", valOut, 0);
    step(0, 8'h00, 1);
    chk(stopOut == 0, "R5 stopOut next", stopOut, 0);

    // R2: one-cycle latency, no same-cycle pass
    step(1, 8'hA1, 0);
    chk(valOut == 0, "R2 same cycle", valOut, 0);
    step(0, 8'h00, 0);
    expectOut("R2 next cycle", 8'hA1);
    step(0, 8'h00, 0);
    chk(valOut == 0, "R12 drained", valOut, 0);

    // R6/R4/R8/R3: stall fills spare slot
    step(1, 8'hB1, 0);
    step(1, 8'hB2, 1);
    chk(valOut == 0, "R3 gated", valOut, 0);
    chk(stopOut == 0, "R6 half no stop", stopOut, 0);
    step(0, 8'h00, 1);
    chk(stopOut == 1, "R4 full stop", stopOut, 1);
    chk(dataOut == 8'hB1, "R8 held", dataOut, 8'hB1);
    step(0, 8'h00, 1);
    chk(dataOut == 8'hB1, "R8 still held", dataOut, 8'hB1);
    step(0, 8'h00, 0);
    expectOut("R6 first", 8'hB1);
    step(0, 8'h00, 0);
    chk(stopOut == 0, "R4 half drops stop", stopOut, 0);
    expectOut("R6 second", 8'hB2);
    step(0, 8'h00, 0);
    chk(valOut == 0, "R3 empty", valOut, 0);

    // R9: pass-through while full
    step(1, 8'hC1, 0);
    step(1, 8'hC2, 1);
    step(1, 8'hC3, 0);
    expectOut("R9 oldest", 8'hC1);
    step(0, 8'h00, 0);
    chk(stopOut == 1, "R9 still full", stopOut, 1);
    expectOut("R9 spare", 8'hC2);
    step(0, 8'h00, 0);
    expectOut("R9 new", 8'hC3);
    step(0, 8'h00, 0);

    // R7: send and refill while one word held
    step(1, 8'hD1, 0);
    step(1, 8'hD2, 0);
    expectOut("R7 held", 8'hD1);
    step(0, 8'h00, 0);
    chk(stopOut == 0, "R7 one held", stopOut, 0);
    expectOut("R7 new", 8'hD2);
    step(0, 8'h00, 0);
    chk(overflow == 0, "R10 no overflow yet", overflow, 0);

    // R10: illegal write sets sticky flag, stored words survive
    step(1, 8'hE1, 0);
    step(1, 8'hE2, 1);
    step(1, 8'hE3, 1);
    step(0, 8'h00, 1);
    chk(overflow == 1, "R10 set", overflow, 1);
    step(0, 8'h00, 0);
    expectOut("R10 first kept", 8'hE1);
    step(0, 8'h00, 0);
    expectOut("R10 second kept", 8'hE2);
    step(0, 8'h00, 0);
    chk(valOut == 0, "R10 dropped word", valOut, 0);
    chk(overflow == 1, "R10 sticky", overflow, 1);

    // R1: reset clears flag
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(overflow == 0, "R1 flag cleared", overflow, 0);

    // R11: random chain traffic
    chainOn = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      snkStop = ($urandom % 3) == 0;
      if (!s0Stop && ($urandom % 4) != 0) begin
        srcVal = 1; srcData = seq; expQ.push_back(seq); seq++;
      end else begin
        srcVal = 0;
      end
    end
    @(negedge clk); srcVal = 0; snkStop = 0;
    repeat (20) @(negedge clk);
    #3;
    chk(expQ.size() == 0, "R11 all delivered", expQ.size(), 0);
    chk({ov0, ov1, ov2} == 3'b000, "R11 no overflow", {ov0, ov1, ov2}, 0);
    chk(seq > 16'd100, "R11 traffic", seq, 100);

    done = 1;
    summary();
    $finish;
  end

endmodule